// File: doc/BRIEF.md
# Real-Time Clock Once-per-Second Update Sequencer

This block runs the once-per-second update of a real-time clock register file. Each time a one-second tick arrives and the oscillator divider field is in its run setting, the block raises an update-in-progress flag. It hands the current internal time to a neighbouring calendar block and loads the advanced time that comes back. A fixed window later it ends the update. At that point it copies the new time into the host-visible time registers, checks the three-byte alarm and posts interrupt flags.

The host reaches all registers through an index plus write and read strobes. A set-mode bit freezes the visible time so software can write a consistent value. Leaving set mode, or writing a time register outside set mode, loads the internal time from the visible registers. The update window is a count of clock cycles, given by a parameter.

The calendar neighbour sits behind one valid/ready request. The block holds `cal_inc_valid` high, with `cal_cur_time` stable, until `cal_inc_ready` is seen high. In that same cycle the neighbour must present the advanced time on `cal_next_time`. A neighbour that keeps ready low stalls the request, and the window counter keeps running meanwhile. The host side has no back-pressure: every strobe takes effect at the clock edge where it is sampled.

Top module: `rtc_upd_ctrl`

## Requirements
- R1: An update starts only on a tick while control A bits 6:4 equal 010. With any other divider value the tick is dropped: the time does not advance and the update flag stays low.
- R2: When an update starts, control A bit 7 (update flag) goes to 1, unless control B bit 7 (set mode) is 1. While set mode is 1 the flag never rises.
- R3: Control A bit 7 is read-only. A host write to control A stores bits 6:0 and leaves bit 7 as it was.
- R4: A host write to control B with bit 7 = 1 clears the update flag. The value stored in control B has bit 4 forced to 0.
- R5: While set mode is 1, a completed update changes only the internal time. The visible time registers keep their values.
- R6: The internal time is reloaded from the visible time registers when a write clears set mode that was 1. It is also reloaded when a time register is written while set mode is 0.
- R7: When control B bit 5 is 1, a completed update checks the seconds, minutes and hours alarm bytes. Each byte matches if its bits 7:6 are both 1 or if it equals the new time byte. When all three match, 0xA0 is ORed into control C.
- R8: The update flag reads 1 for WINDOW_CYCLES cycles after the tick edge and then returns to 0 when the update ends.
- R9: When control B bit 4 is 1, every completed update ORs 0x90 into control C.
- R10: After reset, control A = 0x26, control B = 0x00, control C = 0x00, control D = 0x80, and `irq` is 0.
- R11: `irq` equals control C bit 7. A read of control C returns its value and clears it at that edge, so `irq` falls.
- R12: Host writes to control C and control D have no effect.
- R13: The calendar request stays valid, with its time stable, until ready is seen. The returned time becomes the new internal time.
- R14: The index map is: 0 to 6 are the time bytes (seconds, minutes, hours, weekday, day, month, year), 8 to 10 are the seconds, minutes and hours alarms, and 12 to 15 are controls A, B, C and D. Reads of indexes 7 and 11 return 0. `reg_rdata` shows the indexed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe (clears control C when it is indexed) |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Register selected by `reg_idx` |
| irq | output | 1 | Interrupt request |
| cal_inc_valid | output | 1 | Increment request valid |
| cal_inc_ready | input | 1 | Neighbour accepts the request; `cal_next_time` is valid |
| cal_cur_time | output | 56 | Internal time, byte i = time index i |
| cal_next_time | input | 56 | Advanced time from the calendar neighbour |

## Verification
A wrong internal time stays hidden until the end of the next update. Only then does it surface as a wrong visible byte or a missed alarm, about one window after the tick, so each test reads the time back after a full update. A stuck or mistimed update flag shows in reads of control A within a few cycles of the tick. A flag bit that is set or cleared by mistake in control C shows on `irq` at once. Set-mode faults only appear at the edges of a set-mode period, so those edges are driven while an update is in flight.

// File: rtl/rtc_upd_pkg.sv
package rtc_upd_pkg;
  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 4;
  localparam int NUM_TIME  = 7;
  localparam int NUM_ALARM = 3;
  localparam int TIME_W    = NUM_TIME * BYTE_W;

  localparam logic [IDX_W-1:0] IDX_ALM0  = 4'd8;
  localparam logic [IDX_W-1:0] IDX_CTL_A = 4'd12;
  localparam logic [IDX_W-1:0] IDX_CTL_B = 4'd13;
  localparam logic [IDX_W-1:0] IDX_CTL_C = 4'd14;
  localparam logic [IDX_W-1:0] IDX_CTL_D = 4'd15;

  localparam int B_SET_BIT = 7;
  localparam int B_AIE_BIT = 5;
  localparam int B_UIE_BIT = 4;

  localparam logic [2:0]        DIV_RUN   = 3'b010;
  localparam logic [BYTE_W-1:0] A_RST     = 8'h26;
  localparam logic [BYTE_W-1:0] B_RST     = 8'h00;
  localparam logic [BYTE_W-1:0] D_VALUE   = 8'h80;
  localparam logic [BYTE_W-1:0] FLAG_ALM  = 8'hA0;
  localparam logic [BYTE_W-1:0] FLAG_UEND = 8'h90;

  typedef enum logic [1:0] {ST_IDLE, ST_INC, ST_HOLD} upd_state_e;
endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
  import rtc_upd_pkg::*;
#(
  parameter int WINDOW_CYCLES = 990
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run_ok,
  input  logic cal_ready,
  output logic cal_valid,
  output logic upd_start,
  output logic upd_done
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  upd_state_e       state;
  logic [CNT_W-1:0] cnt;

  assign upd_start = (state == ST_IDLE) && tick && run_ok;
  assign cal_valid = (state == ST_INC);
  assign upd_done  = (state == ST_HOLD) && (cnt >= LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (upd_start) begin
          state <= ST_INC;
          cnt   <= '0;
        end
        ST_INC: begin
          if (cnt < LAST) cnt <= cnt + 1'b1;
          if (cal_ready) state <= ST_HOLD;
        end
        ST_HOLD: begin
          if (upd_done) state <= ST_IDLE;
          else          cnt   <= cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_upd_pkg::*;
#(
  parameter int FIELDS = NUM_ALARM
) (
  input  logic [FIELDS*BYTE_W-1:0] alarm_bytes,
  input  logic [FIELDS*BYTE_W-1:0] time_bytes,
  output logic                     hit
);
  logic [FIELDS-1:0] field_ok;

  for (genvar g = 0; g < FIELDS; g++) begin : g_field
    logic [BYTE_W-1:0] al, tm;
    assign al = alarm_bytes[g*BYTE_W +: BYTE_W];
    assign tm = time_bytes[g*BYTE_W +: BYTE_W];
    assign field_ok[g] = (al[BYTE_W-1 -: 2] == 2'b11) || (al == tm);
  end

  assign hit = &field_ok;
endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
  import rtc_upd_pkg::*;
#(
  parameter int WINDOW_CYCLES = 990
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              cal_inc_valid,
  input  logic              cal_inc_ready,
  output logic [TIME_W-1:0] cal_cur_time,
  input  logic [TIME_W-1:0] cal_next_time
);
  logic [BYTE_W-1:0] vis [NUM_TIME];
  logic [BYTE_W-1:0] alm [NUM_ALARM];
  logic [TIME_W-1:0] shadow;
  logic [6:0]        a_low;
  logic              uip;
  logic [BYTE_W-1:0] ctl_b, ctl_c;

  logic upd_start, upd_done, alarm_hit, run_ok, set_mode;
  logic wr_time, wr_a, wr_b, rd_c;
  logic [TIME_W-1:0] vis_merged;
  logic [NUM_ALARM*BYTE_W-1:0] alm_packed;
  logic [BYTE_W-1:0] c_next;

  assign set_mode = ctl_b[B_SET_BIT];
  assign run_ok   = (a_low[6:4] == DIV_RUN);
  assign wr_time  = reg_wr && (reg_idx < IDX_W'(NUM_TIME));
  assign wr_a     = reg_wr && (reg_idx == IDX_CTL_A);
  assign wr_b     = reg_wr && (reg_idx == IDX_CTL_B);
  assign rd_c     = reg_rd && (reg_idx == IDX_CTL_C);

  for (genvar t = 0; t < NUM_TIME; t++) begin : g_merge
    assign vis_merged[t*BYTE_W +: BYTE_W] =
      (wr_time && reg_idx == IDX_W'(t)) ? reg_wdata : vis[t];
  end
  for (genvar a = 0; a < NUM_ALARM; a++) begin : g_apack
    assign alm_packed[a*BYTE_W +: BYTE_W] = alm[a];
  end

  rtc_upd_seq #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (sec_tick),
    .run_ok    (run_ok),
    .cal_ready (cal_inc_ready),
    .cal_valid (cal_inc_valid),
    .upd_start (upd_start),
    .upd_done  (upd_done)
  );

  rtc_alarm_match #(.FIELDS(NUM_ALARM)) u_alarm (
    .alarm_bytes (alm_packed),
    .time_bytes  (shadow[NUM_ALARM*BYTE_W-1:0]),
    .hit         (alarm_hit)
  );

  always_comb begin
    c_next = rd_c ? '0 : ctl_c;
    if (upd_done) begin
      if (ctl_b[B_AIE_BIT] && alarm_hit) c_next = c_next | FLAG_ALM;
      if (ctl_b[B_UIE_BIT])              c_next = c_next | FLAG_UEND;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_TIME; i++) vis[i] <= '0;
      for (int i = 0; i < NUM_ALARM; i++) alm[i] <= '0;
      shadow <= '0;
      a_low  <= A_RST[6:0];
      uip    <= A_RST[7];
      ctl_b  <= B_RST;
      ctl_c  <= '0;
    end else begin
      for (int i = 0; i < NUM_TIME; i++) begin
        if (wr_time && reg_idx == IDX_W'(i))
          vis[i] <= reg_wdata;
        else if (upd_done && !set_mode)
          vis[i] <= shadow[i*BYTE_W +: BYTE_W];
      end
      for (int i = 0; i < NUM_ALARM; i++)
        if (reg_wr && reg_idx == IDX_ALM0 + IDX_W'(i)) alm[i] <= reg_wdata;

      if ((wr_time && !set_mode) || (wr_b && !reg_wdata[B_SET_BIT] && set_mode))
        shadow <= vis_merged;
      else if (cal_inc_valid && cal_inc_ready)
        shadow <= cal_next_time;

      if (wr_a) a_low <= reg_wdata[6:0];

      if (upd_done || (wr_b && reg_wdata[B_SET_BIT]))
        uip <= 1'b0;
      else if (upd_start && !set_mode)
        uip <= 1'b1;

      if (wr_b) begin
        ctl_b <= reg_wdata;
        if (reg_wdata[B_SET_BIT]) ctl_b[B_UIE_BIT] <= 1'b0;
      end

      ctl_c <= c_next;
    end
  end

  assign irq          = ctl_c[7];
  assign cal_cur_time = shadow;

  always_comb begin
    reg_rdata = '0;
    if (reg_idx < IDX_W'(NUM_TIME)) reg_rdata = vis[reg_idx[2:0]];
    else if (reg_idx >= IDX_ALM0 && reg_idx < IDX_ALM0 + IDX_W'(NUM_ALARM))
      reg_rdata = alm[reg_idx - IDX_ALM0];
    else begin
      case (reg_idx)
        IDX_CTL_A: reg_rdata = {uip, a_low};
        IDX_CTL_B: reg_rdata = ctl_b;
        IDX_CTL_C: reg_rdata = ctl_c;
        IDX_CTL_D: reg_rdata = D_VALUE;
        default:   reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_upd_ctrl_chk.sv
module rtc_upd_ctrl_chk
  import rtc_upd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sec_tick,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [IDX_W-1:0]  reg_idx,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic              irq,
  input logic              cal_inc_valid,
  input logic              cal_inc_ready,
  input logic [TIME_W-1:0] cal_cur_time,
  input logic              uip,
  input logic              run_ok,
  input logic [BYTE_W-1:0] ctl_b,
  input logic [BYTE_W-1:0] ctl_c,
  input logic              upd_start,
  input logic              upd_done,
  input logic [BYTE_W-1:0] vis_sec
);
  logic host_touch;
  assign host_touch = reg_wr && ((reg_idx < IDX_W'(NUM_TIME)) || reg_idx == IDX_CTL_B);

  a_r1_bad_div_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !run_ok && !uip) |=> !uip);

  a_r2_set_blocks_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_b[B_SET_BIT] && !uip) |=> !uip);

  a_r3_flag_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_CTL_A && !upd_start && !upd_done) |=> (uip == $past(uip)));

  a_r4_set_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_idx == IDX_CTL_B && reg_wdata[B_SET_BIT]) |=> (!uip && !ctl_b[B_UIE_BIT]));

  a_r5_visible_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_b[B_SET_BIT] && !(reg_wr && reg_idx == '0)) |=> $stable(vis_sec));

  a_r9_update_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && ctl_b[B_UIE_BIT]) |=> (ctl_c[7] && ctl_c[4]));

  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_idx == IDX_CTL_C && !upd_done) |=> !irq);

  a_r13_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_inc_valid && !cal_inc_ready && !host_touch) |=> (cal_inc_valid && $stable(cal_cur_time)));
endmodule

bind rtc_upd_ctrl rtc_upd_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sec_tick      (sec_tick),
  .reg_wr        (reg_wr),
  .reg_rd        (reg_rd),
  .reg_idx       (reg_idx),
  .reg_wdata     (reg_wdata),
  .irq           (irq),
  .cal_inc_valid (cal_inc_valid),
  .cal_inc_ready (cal_inc_ready),
  .cal_cur_time  (cal_cur_time),
  .uip           (uip),
  .run_ok        (run_ok),
  .ctl_b         (ctl_b),
  .ctl_c         (ctl_c),
  .upd_start     (upd_start),
  .upd_done      (upd_done),
  .vis_sec       (vis[0])
);

// File: tb/rtc_upd_ctrl_tb.sv
module rtc_upd_ctrl_tb;
  import rtc_upd_pkg::*;

  localparam int WIN = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sec_tick = 1'b0;
  logic              reg_wr = 1'b0;
  logic              reg_rd = 1'b0;
  logic [IDX_W-1:0]  reg_idx = '0;
  logic [BYTE_W-1:0] reg_wdata = '0;
  logic [BYTE_W-1:0] reg_rdata;
  logic              irq;
  logic              cal_inc_valid;
  logic              cal_inc_ready;
  logic [TIME_W-1:0] cal_cur_time;
  logic [TIME_W-1:0] cal_next_time;
  logic              cal_stall = 1'b0;

  int checks = 0;
  int errors = 0;

  typedef struct {
    string             req;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] exp;
    logic [BYTE_W-1:0] mask;
  } rd_item_t;
  rd_item_t rd_q[$];

  always #2 clk = ~clk;

  // calendar neighbour model: seconds byte + 1
  assign cal_inc_ready = !cal_stall;
  assign cal_next_time = {cal_cur_time[TIME_W-1:8], cal_cur_time[7:0] + 8'd1};

  rtc_upd_ctrl #(.WINDOW_CYCLES(WIN)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_idx       (reg_idx),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq           (irq),
    .cal_inc_valid (cal_inc_valid),
    .cal_inc_ready (cal_inc_ready),
    .cal_cur_time  (cal_cur_time),
    .cal_next_time (cal_next_time)
  );

  task automatic chk(input string req, input logic [BYTE_W-1:0] act, input logic [BYTE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard while a read strobe is held
  always @(negedge clk) begin
    #1;
    if (reg_rd) begin
      if (rd_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard empty actual=0x%02h expected=none", reg_rdata);
      end else begin
        rd_item_t it;
        it = rd_q.pop_front();
        chk(it.req, reg_rdata & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [IDX_W-1:0] idx, input logic [BYTE_W-1:0] d);
    @(negedge clk);
    reg_idx = idx; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string req, input logic [IDX_W-1:0] idx,
                    input logic [BYTE_W-1:0] exp, input logic [BYTE_W-1:0] mask = 8'hFF);
    rd_item_t it;
    @(negedge clk);
    it.req = req; it.idx = idx; it.exp = exp; it.mask = mask;
    rd_q.push_back(it);
    reg_idx = idx; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(posedge clk); #1;
    sec_tick = 1'b0;
  endtask

  task automatic settle();
    repeat (WIN + 4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] sec;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    @(negedge clk); #1;
    chk("R10 irq", {7'd0, irq}, 8'h00);
    rd("R10 A", IDX_CTL_A, 8'h26);
    rd("R10 B", IDX_CTL_B, 8'h00);
    rd("R10 C", IDX_CTL_C, 8'h00);
    rd("R10 D", IDX_CTL_D, 8'h80);

    // R6/R14 time writes with set mode off reload internal time
    wr(4'd0, 8'h10); wr(4'd1, 8'h20); wr(4'd2, 8'h05);
    sec = 8'h10;
    rd("R14 min", 4'd1, 8'h20);
    rd("R14 unmapped 7", 4'd7, 8'h00);
    rd("R14 unmapped 11", 4'd11, 8'h00);

    // R3 idle write to A keeps flag
    wr(IDX_CTL_A, 8'hA6);
    rd("R3 idle", IDX_CTL_A, 8'h26);

    // R2/R8/R3 update window
    tick();
    rd("R2 flag set", IDX_CTL_A, 8'h80, 8'h80);
    wr(IDX_CTL_A, 8'h26);
    rd("R3 busy", IDX_CTL_A, 8'hA6);
    repeat (WIN - 8) @(negedge clk);
    rd("R8 still set", IDX_CTL_A, 8'h80, 8'h80);
    settle();
    rd("R8 cleared", IDX_CTL_A, 8'h26);
    sec = sec + 1;
    rd("R1 advanced", 4'd0, sec);

    // R1 bad divider
    wr(IDX_CTL_A, 8'h06);
    tick();
    rd("R1 no flag", IDX_CTL_A, 8'h00, 8'h80);
    settle();
    rd("R1 held", 4'd0, sec);
    wr(IDX_CTL_A, 8'h26);

    // R9/R11 update-ended flag
    wr(IDX_CTL_B, 8'h10);
    tick(); settle(); sec = sec + 1;
    chk("R11 irq up", {7'd0, irq}, 8'h01);
    rd("R9 C", IDX_CTL_C, 8'h90);
    @(negedge clk); #1;
    chk("R11 irq down", {7'd0, irq}, 8'h00);
    rd("R11 C cleared", IDX_CTL_C, 8'h00);

    // R7 alarm: don't-care min/hr, exact sec
    wr(IDX_CTL_B, 8'h20);
    wr(4'd8, sec + 8'd1); wr(4'd9, 8'hC0); wr(4'd10, 8'hFF);
    tick(); settle(); sec = sec + 1;
    rd("R7 match", IDX_CTL_C, 8'hA0);
    tick(); settle(); sec = sec + 1;
    rd("R7 miss", IDX_CTL_C, 8'h00);
    wr(4'd8, 8'hC0); wr(4'd9, 8'h20); wr(4'd10, 8'h05);
    tick(); settle(); sec = sec + 1;
    rd("R7 exact min/hr", IDX_CTL_C, 8'hA0);
    wr(4'd9, 8'h21);
    tick(); settle(); sec = sec + 1;
    rd("R7 min differs", IDX_CTL_C, 8'h00);
    rd("R7 time", 4'd0, sec);

    // R4/R5 set mode entered mid-update
    wr(IDX_CTL_B, 8'h10);
    tick();
    rd("R2 flag before set", IDX_CTL_A, 8'h80, 8'h80);
    wr(IDX_CTL_B, 8'h90);
    rd("R4 flag cleared", IDX_CTL_A, 8'h00, 8'h80);
    rd("R4 B stored", IDX_CTL_B, 8'h80);
    settle();
    rd("R5 visible frozen", 4'd0, sec);
    rd("R4 no end flag", IDX_CTL_C, 8'h00);
    tick();
    rd("R2 set blocks flag", IDX_CTL_A, 8'h00, 8'h80);
    settle();
    rd("R5 still frozen", 4'd0, sec);

    // R6 reload on leaving set mode
    wr(4'd0, 8'h40);
    rd("R5 host write", 4'd0, 8'h40);
    wr(IDX_CTL_B, 8'h00);
    tick(); settle();
    rd("R6 reload", 4'd0, 8'h41);

    // R13 stalled calendar request
    cal_stall = 1'b1;
    tick();
    repeat (3) begin
      @(negedge clk); #1;
      chk("R13 valid held", {7'd0, cal_inc_valid}, 8'h01);
      chk("R13 time stable", cal_cur_time[7:0], 8'h41);
    end
    cal_stall = 1'b0;
    settle();
    chk("R13 no request", {7'd0, cal_inc_valid}, 8'h00);
    rd("R13 new time", 4'd0, 8'h42);

    // R12 writes to C and D ignored
    wr(IDX_CTL_C, 8'hFF);
    wr(IDX_CTL_D, 8'h00);
    @(negedge clk); #1;
    chk("R12 irq", {7'd0, irq}, 8'h00);
    rd("R12 C", IDX_CTL_C, 8'h00);
    rd("R12 D", IDX_CTL_D, 8'h80);

    repeat (4) @(negedge clk);
    if (rd_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", rd_q.size());
    end
    finish_run();
  end
endmodule